// File: doc/BRIEF.md
# Dual Logic Analyzer Trigger Unit

This block watches a stream of 32-bit logic-analyzer samples and issues one trigger pulse when its configured conditions are met. It accepts at most one sample per clock, on cycles where the valid input is high. It holds two independent condition evaluators. Each evaluator can combine up to four kinds of test:

- an edge test on one selected channel;
- a range test on a bus value that is gathered from any set of channels and packed into a gapless, zero-extended number;
- a duration test on how many samples that range relation stayed true;
- a masked pattern match that can be paired with the other tests on the sample before it, on the same sample, or on the sample after it.

The outputs of the two evaluators are gated by per-evaluator enables and merged with OR or AND. The merged result is registered into a single-cycle pulse. An arm input starts a capture window, and the unit fires at most once per window. Pretrigger buffering and sample storage live outside this block.

Top module: `ladt_trigger_unit`

## Requirements
- R1: The range test works on a packed value. Each sample bit whose mask bit is 1 is placed, in ascending bit order, into consecutive bits starting at bit 0, and the upper bits are zero. For example, mask 0x43 applied to sample 0xD1 gives 5.
- R2: Control bits [4:0] pick the edge channel. Bits [6:5] pick the edge kind: 0 rising, 1 falling, 2 either, 3 edge test off. The first sample after arm never counts as an edge.
- R3: Control bit 12 enables the range test, and bits [9:8] pick its relation as an unsigned comparison. The relations are: 0 means value equals the maximum; 1 means value equals the minimum or the maximum; 2 means value is below the minimum or above the maximum; 3 means value is strictly between the two.
- R4: Control bit 13 enables the duration test. It counts consecutive valid samples for which the range relation holds. The count saturates at 2^CW-1. The test is judged on the first valid sample where the relation fails, using the same four relations selected by bits [11:10] against the duration limits. While the duration test is on, bit 12 is ignored.
- R5: Control bit 18 enables the pattern test. A sample matches when it equals the pattern data on every bit of the pattern mask. Bits [17:16] choose where the other enabled tests are judged: 1 on the matching sample, 2 on the sample before it, 0 on the sample after it. Code 3 disables the pattern test.
- R6: Within one evaluator, every enabled test must hold together. An evaluator with no test enabled never fires.
- R7: The trigger-enable input has bit 0 for evaluator 0 and bit 1 for evaluator 1. Enabled results are ORed when merge_and is 0. When merge_and is 1 they are ANDed, and in that case both evaluators must be enabled.
- R8: A firing sample produces trig_pulse high for exactly the next cycle. After that, no further pulse occurs until arm is pulsed again. Arm clears all sample history. A sample offered in the same cycle as arm is ignored. Cycles without valid change nothing.
- R9: After reset, trig_pulse is low and the unit is disarmed until the first arm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm | input | 1 | Starts a new capture window and clears history |
| smp_valid | input | 1 | Sample on smp_data is present |
| smp_data | input | W | Sample, one bit per channel |
| cond_ctl | input | 2x32 | Per-evaluator control word (fields in R2 to R5) |
| rng_lo | input | 2xW | Range minimum, packed form |
| rng_hi | input | 2xW | Range maximum, packed form |
| rng_mask | input | 2xW | Channels gathered into the range value |
| dur_lo | input | 2xCW | Duration minimum, in samples |
| dur_hi | input | 2xCW | Duration maximum, in samples |
| pat_mask | input | 2xW | Channels compared by the pattern test |
| pat_data | input | 2xW | Pattern value |
| trig_en | input | 2 | Per-evaluator enable |
| merge_and | input | 1 | 1: AND merge, 0: OR merge |
| trig_pulse | output | 1 | Single-cycle trigger pulse |

## Verification
The hardest state to reach is a saturated duration counter, because a run of 2^32 samples cannot be driven. The bench therefore builds the unit with a 6-bit counter and holds the range relation true for 70 samples, which passes the limit. The run then ends with a maximum of 63, so only a counter that holds at its ceiling fires; a wrapping counter would report 6. The before and after pattern pairings each need two samples in a set order right after arm. Directed pairs place them there, and randomized windows mix all modes against a bench model.

// File: rtl/ladt_pkg.sv
package ladt_pkg;

   typedef enum logic [1:0] {
      EDG_RISE = 2'd0,
      EDG_FALL = 2'd1,
      EDG_ANY  = 2'd2,
      EDG_OFF  = 2'd3
   } edge_kind_e;

   typedef enum logic [1:0] {
      PSEL_NEXT = 2'd0,
      PSEL_CURR = 2'd1,
      PSEL_PREV = 2'd2,
      PSEL_NONE = 2'd3
   } pat_sel_e;

   // Four-way unsigned relation shared by the range and duration tests.
   function automatic logic rel_hit(input logic [1:0] md, input logic [63:0] x,
                                    input logic [63:0] lo, input logic [63:0] hi);
      case (md)
         2'd0:    return (x == hi);
         2'd1:    return (x == lo) || (x == hi);
         2'd2:    return (x < lo) || (x > hi);
         default: return (x > lo) && (x < hi);
      endcase
   endfunction

endpackage

// File: rtl/ladt_bus_pack.sv
module ladt_bus_pack #(
   parameter int W = 32
) (
   input  logic [W-1:0] mask,
   input  logic [W-1:0] val,
   output logic [W-1:0] packed_val
);
   localparam int CNTW = $clog2(W + 1);

   logic [CNTW-1:0] pos;

   always_comb begin
      packed_val = '0;
      pos        = '0;
      for (int i = 0; i < W; i++) begin
         if (mask[i]) begin
            packed_val = packed_val | ({{(W-1){1'b0}}, val[i]} << pos);
            pos        = pos + 1'b1;
         end
      end
   end

endmodule

// File: rtl/ladt_cond_eval.sv
module ladt_cond_eval
   import ladt_pkg::*;
#(
   parameter int W  = 32,
   parameter int CW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          valid,
   input  logic [W-1:0]  smp,
   input  logic [31:0]   ctl,
   input  logic [W-1:0]  rng_lo,
   input  logic [W-1:0]  rng_hi,
   input  logic [W-1:0]  rng_mask,
   input  logic [CW-1:0] dur_lo,
   input  logic [CW-1:0] dur_hi,
   input  logic [W-1:0]  pat_mask,
   input  logic [W-1:0]  pat_data,
   output logic          hit
);
   localparam int SW = $clog2(W);
   localparam logic [CW-1:0] CMAX = '1;

   logic [W-1:0]  prev_q;
   logic          hv_q, othp_q, pmp_q;
   logic [CW-1:0] run_q;
   logic [W-1:0]  pv;
   logic          adv, rok, cur_b, prv_b, eh, dh, oth, pm, any_en;
   logic          edge_en, rng_en, dur_en, pat_en;
   edge_kind_e    ek;
   pat_sel_e      ps;
   logic          unused_ctl;

   assign unused_ctl = ^{ctl[31:19], ctl[15:14], ctl[7]};

   ladt_bus_pack #(.W(W)) u_pack (
      .mask      (rng_mask),
      .val       (smp),
      .packed_val(pv)
   );

   assign adv = valid & ~clr;
   assign ek  = edge_kind_e'(ctl[6:5]);
   assign ps  = pat_sel_e'(ctl[17:16]);

   always_comb begin
      rok     = rel_hit(ctl[9:8], 64'(pv), 64'(rng_lo), 64'(rng_hi));
      cur_b   = smp[ctl[SW-1:0]];
      prv_b   = prev_q[ctl[SW-1:0]];
      case (ek)
         EDG_RISE: eh = hv_q & ~prv_b & cur_b;
         EDG_FALL: eh = hv_q & prv_b & ~cur_b;
         EDG_ANY:  eh = hv_q & (prv_b ^ cur_b);
         default:  eh = 1'b0;
      endcase
      edge_en = (ek != EDG_OFF);
      dur_en  = ctl[13];
      rng_en  = ctl[12] & ~dur_en;
      pat_en  = ctl[18] & (ps != PSEL_NONE);
      dh      = ~rok & (run_q != '0) &
                rel_hit(ctl[11:10], 64'(run_q), 64'(dur_lo), 64'(dur_hi));
      oth     = (~edge_en | eh) & (~rng_en | rok) & (~dur_en | dh);
      pm      = ((smp ^ pat_data) & pat_mask) == '0;
      any_en  = edge_en | rng_en | dur_en | pat_en;
      if (!any_en)
         hit = 1'b0;
      else if (!pat_en)
         hit = oth;
      else if (ps == PSEL_CURR)
         hit = pm & oth;
      else if (ps == PSEL_PREV)
         hit = pm & othp_q;
      else
         hit = pmp_q & oth;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= '0;
         hv_q   <= 1'b0;
         run_q  <= '0;
         othp_q <= 1'b0;
         pmp_q  <= 1'b0;
      end else if (clr) begin
         prev_q <= '0;
         hv_q   <= 1'b0;
         run_q  <= '0;
         othp_q <= 1'b0;
         pmp_q  <= 1'b0;
      end else if (adv) begin
         prev_q <= smp;
         hv_q   <= 1'b1;
         run_q  <= rok ? ((run_q == CMAX) ? CMAX : run_q + 1'b1) : '0;
         othp_q <= oth;
         pmp_q  <= pm;
      end
   end

   // R4: the duration count holds at its ceiling
   p_cnt_sat_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && rok && run_q == CMAX) |=> (run_q == CMAX));

   // R6: no enabled test means no hit
   p_no_test_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl[6:5] == 2'b11 && ctl[12] == 1'b0 && ctl[13] == 1'b0 && ctl[18] == 1'b0) |-> !hit);

endmodule

// File: rtl/ladt_trigger_unit.sv
module ladt_trigger_unit #(
   parameter int W  = 32,
   parameter int CW = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                arm,
   input  logic                smp_valid,
   input  logic [W-1:0]        smp_data,
   input  logic [1:0][31:0]    cond_ctl,
   input  logic [1:0][W-1:0]   rng_lo,
   input  logic [1:0][W-1:0]   rng_hi,
   input  logic [1:0][W-1:0]   rng_mask,
   input  logic [1:0][CW-1:0]  dur_lo,
   input  logic [1:0][CW-1:0]  dur_hi,
   input  logic [1:0][W-1:0]   pat_mask,
   input  logic [1:0][W-1:0]   pat_data,
   input  logic [1:0]          trig_en,
   input  logic                merge_and,
   output logic                trig_pulse
);
   localparam int NCOND = 2;

   if (W < 2 || W > 32 || W != (1 << $clog2(W)))
      $error("W must be a power of two between 2 and 32");
   if (CW < 2 || CW > 32)
      $error("CW must lie between 2 and 32");

   logic [NCOND-1:0] hits, gated;
   logic             fire, go, armed_q;

   for (genvar g = 0; g < NCOND; g++) begin : g_cond
      ladt_cond_eval #(.W(W), .CW(CW)) u_cond (
         .clk     (clk),
         .rst_n   (rst_n),
         .clr     (arm),
         .valid   (smp_valid),
         .smp     (smp_data),
         .ctl     (cond_ctl[g]),
         .rng_lo  (rng_lo[g]),
         .rng_hi  (rng_hi[g]),
         .rng_mask(rng_mask[g]),
         .dur_lo  (dur_lo[g]),
         .dur_hi  (dur_hi[g]),
         .pat_mask(pat_mask[g]),
         .pat_data(pat_data[g]),
         .hit     (hits[g])
      );
   end

   always_comb begin
      gated = trig_en & hits;
      fire  = merge_and ? (&gated) : (|gated);
      go    = armed_q & smp_valid & ~arm & fire;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q    <= 1'b0;
         trig_pulse <= 1'b0;
      end else begin
         trig_pulse <= go;
         if (arm)
            armed_q <= 1'b1;
         else if (go)
            armed_q <= 1'b0;
      end
   end

   // R8: pulse lasts one cycle
   p_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      trig_pulse |=> !trig_pulse);

   // R8: pulse only follows an accepted sample
   p_after_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
      trig_pulse |-> ($past(smp_valid) && !$past(arm)));

   // R8: an arm cycle never produces a pulse on the next cycle
   p_arm_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      arm |=> !trig_pulse);

endmodule

// File: tb/ladt_trigger_unit_tb_top.sv
module ladt_trigger_unit_tb_top;
   localparam int W  = 32;
   localparam int CW = 6;
   localparam int unsigned CMAX = (1 << CW) - 1;

   logic clk = 1'b0, rst_n = 1'b0, arm = 1'b0, smp_valid = 1'b0;
   logic [W-1:0]         smp_data = '0;
   logic [1:0][31:0]     cond_ctl;
   logic [1:0][W-1:0]    rng_lo, rng_hi, rng_mask, pat_mask, pat_data;
   logic [1:0][CW-1:0]   dur_lo, dur_hi;
   logic [1:0]           trig_en;
   logic                 merge_and;
   logic                 trig_pulse;

   int n_vec = 0, n_bad = 0;

   logic [31:0] m_prev;
   bit          m_hv, m_armed;
   int unsigned m_run [2];
   bit          m_othp [2], m_pmp [2];

   always #10 clk = ~clk;

   ladt_trigger_unit #(.W(W), .CW(CW)) dut_i (
      .clk(clk), .rst_n(rst_n), .arm(arm), .smp_valid(smp_valid), .smp_data(smp_data),
      .cond_ctl(cond_ctl), .rng_lo(rng_lo), .rng_hi(rng_hi), .rng_mask(rng_mask),
      .dur_lo(dur_lo), .dur_hi(dur_hi), .pat_mask(pat_mask), .pat_data(pat_data),
      .trig_en(trig_en), .merge_and(merge_and), .trig_pulse(trig_pulse)
   );

   function automatic logic [31:0] gather(input logic [31:0] m, input logic [31:0] v);
      logic [31:0] r = '0;
      int j = 0;
      for (int i = 0; i < 32; i++)
         if (m[i]) begin
            r[j] = v[i];
            j++;
         end
      return r;
   endfunction

   function automatic bit relate(input logic [1:0] md, input longint unsigned x,
                                 input longint unsigned lo, input longint unsigned hi);
      if (md == 0) return x == hi;
      if (md == 1) return x == lo || x == hi;
      if (md == 2) return x < lo || x > hi;
      return x > lo && x < hi;
   endfunction

   task automatic judge(input int k, input logic [31:0] s, output bit h,
                        output bit oth, output bit pm, output bit rok);
      logic [31:0] c = cond_ctl[k];
      bit e_on, r_on, d_on, p_on, eh, dh, cb, pb;
      rok  = relate(c[9:8], gather(rng_mask[k], s), rng_lo[k], rng_hi[k]);
      cb   = s[c[4:0]];
      pb   = m_prev[c[4:0]];
      e_on = c[6:5] != 2'd3;
      eh   = m_hv && ((c[6:5] == 0 && !pb && cb) || (c[6:5] == 1 && pb && !cb) ||
                      (c[6:5] == 2 && pb != cb));
      d_on = c[13];
      r_on = c[12] && !d_on;
      p_on = c[18] && c[17:16] != 2'd3;
      dh   = !rok && m_run[k] > 0 && relate(c[11:10], m_run[k], dur_lo[k], dur_hi[k]);
      oth  = (!e_on || eh) && (!r_on || rok) && (!d_on || dh);
      pm   = ((s ^ pat_data[k]) & pat_mask[k]) == 0;
      if (!(e_on || r_on || d_on || p_on)) h = 0;
      else if (!p_on) h = oth;
      else if (c[17:16] == 1) h = pm && oth;
      else if (c[17:16] == 2) h = pm && m_othp[k];
      else h = m_pmp[k] && oth;
   endtask

   task automatic cyc(input bit v, input logic [31:0] s, input bit a,
                      input string tag, input int want = -1);
      bit exp = 0;
      bit h [2], o [2], p [2], r [2];
      bit t;
      smp_valid = v; smp_data = s; arm = a;
      if (a) begin
         m_hv = 0; m_armed = 1; m_prev = 0;
         for (int k = 0; k < 2; k++) begin m_run[k] = 0; m_othp[k] = 0; m_pmp[k] = 0; end
      end else if (v) begin
         for (int k = 0; k < 2; k++) judge(k, s, h[k], o[k], p[k], r[k]);
         t = merge_and ? (trig_en[0] && h[0] && trig_en[1] && h[1])
                       : ((trig_en[0] && h[0]) || (trig_en[1] && h[1]));
         exp = m_armed && t;
         if (exp) m_armed = 0;
         m_prev = s; m_hv = 1;
         for (int k = 0; k < 2; k++) begin
            m_run[k]  = r[k] ? ((m_run[k] == CMAX) ? CMAX : m_run[k] + 1) : 0;
            m_othp[k] = o[k];
            m_pmp[k]  = p[k];
         end
      end
      @(posedge clk);
      @(negedge clk);
      n_vec++;
      if (trig_pulse !== exp) begin
         n_bad++;
         $display("FAIL %s model: actual=%b expected=%b", tag, trig_pulse, exp);
      end
      if (want >= 0) begin
         n_vec++;
         if (trig_pulse !== want[0]) begin
            n_bad++;
            $display("FAIL %s directed: actual=%b expected=%b", tag, trig_pulse, want[0]);
         end
      end
   endtask

   task automatic base_cfg();
      cond_ctl = '{32'h60, 32'h60};
      rng_lo = '0; rng_hi = '0; rng_mask = '0; pat_mask = '0; pat_data = '0;
      dur_lo = '0; dur_hi = '0; trig_en = 2'b01; merge_and = 1'b0;
   endtask

   task automatic rearm(input string tag);
      cyc(0, 0, 1, tag, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL R8 watchdog: actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd7741));
      base_cfg();
      m_prev = 0; m_hv = 0; m_armed = 0;
      for (int k = 0; k < 2; k++) begin m_run[k] = 0; m_othp[k] = 0; m_pmp[k] = 0; end
      repeat (2) @(negedge clk);
      n_vec++;
      if (trig_pulse !== 1'b0) begin
         n_bad++;
         $display("FAIL R9 reset: actual=%b expected=0", trig_pulse);
      end
      rst_n = 1'b1;

      // R9: disarmed after reset although the range test always holds
      cond_ctl[0] = 32'h1060;
      cyc(1, 32'h5, 0, "R9", 0);

      // R1: mask 0x43 on 0xD1 packs to 5
      rng_mask[0] = 32'h43; rng_hi[0] = 5;
      rearm("R1"); cyc(1, 32'hD1, 0, "R1", 1);
      rearm("R1"); cyc(1, 32'hD0, 0, "R1", 0);

      // R3: the four range relations
      rng_mask[0] = 32'hF; rng_lo[0] = 2; rng_hi[0] = 5;
      cond_ctl[0] = 32'h1360;
      rearm("R3"); cyc(1, 2, 0, "R3", 0); cyc(1, 3, 0, "R3", 1);
      cond_ctl[0] = 32'h1260;
      rearm("R3"); cyc(1, 3, 0, "R3", 0); cyc(1, 6, 0, "R3", 1);
      cond_ctl[0] = 32'h1160;
      rearm("R3"); cyc(1, 4, 0, "R3", 0); cyc(1, 2, 0, "R3", 1);

      // R2: edges on channel 3
      cond_ctl[0] = 32'h03;
      rearm("R2"); cyc(1, 8, 0, "R2", 0); cyc(1, 0, 0, "R2", 0); cyc(1, 8, 0, "R2", 1);
      cond_ctl[0] = 32'h23;
      rearm("R2"); cyc(1, 8, 0, "R2", 0); cyc(1, 0, 0, "R2", 1);
      cond_ctl[0] = 32'h43;
      rearm("R2"); cyc(1, 0, 0, "R2", 0); cyc(1, 8, 0, "R2", 1);
      // R6: nothing enabled never fires
      cond_ctl[0] = 32'h63;
      rearm("R6"); cyc(1, 0, 0, "R6", 0); cyc(1, 8, 0, "R6", 0); cyc(1, 0, 0, "R6", 0);

      // R6: edge and range must hold together
      cond_ctl[0] = 32'h1000; rng_mask[0] = 32'hF0; rng_hi[0] = 1;
      rearm("R6"); cyc(1, 32'h10, 0, "R6", 0); cyc(1, 32'h11, 0, "R6", 1);
      rearm("R6"); cyc(1, 32'h00, 0, "R6", 0); cyc(1, 32'h01, 0, "R6", 0);

      // R4: saturation with a 6-bit counter, run of 70
      cond_ctl[0] = 32'h2060; rng_mask[0] = 1; rng_hi[0] = 1; dur_hi[0] = 6'd63;
      rearm("R4");
      for (int i = 0; i < 70; i++) cyc(1, 1, 0, "R4", 0);
      cyc(1, 0, 0, "R4 saturated", 1);
      // R4: strictly-between duration, gaps in valid do not break the run
      cond_ctl[0] = 32'h2C60; dur_lo[0] = 1; dur_hi[0] = 4;
      rearm("R4"); cyc(1, 1, 0, "R4", 0); cyc(0, 0, 0, "R4", 0); cyc(1, 1, 0, "R4", 0);
      cyc(1, 1, 0, "R4", 0); cyc(1, 0, 0, "R4", 1);
      // R4: range enable ignored while duration is on
      cond_ctl[0] = 32'h3060; dur_hi[0] = 6'd63;
      rearm("R4"); cyc(1, 1, 0, "R4", 0); cyc(1, 0, 0, "R4", 0);

      // R5: pattern pairing
      rng_mask[0] = 32'hF; rng_hi[0] = 3; pat_mask[0] = 32'hF0; pat_data[0] = 32'h50;
      cond_ctl[0] = 32'h51060;
      rearm("R5"); cyc(1, 32'h53, 0, "R5 current", 1);
      rearm("R5"); cyc(1, 32'h03, 0, "R5 current", 0);
      cond_ctl[0] = 32'h61060;
      rearm("R5"); cyc(1, 32'h03, 0, "R5 previous", 0); cyc(1, 32'h50, 0, "R5 previous", 1);
      cond_ctl[0] = 32'h41060;
      rearm("R5"); cyc(1, 32'h50, 0, "R5 next", 0); cyc(1, 32'h03, 0, "R5 next", 1);
      cond_ctl[0] = 32'h71060;
      rearm("R5"); cyc(1, 32'h03, 0, "R5 code3", 1);
      cond_ctl[0] = 32'h50060;
      rearm("R5"); cyc(1, 32'h5A, 0, "R5 alone", 1);

      // R7: merging
      base_cfg();
      cond_ctl[0] = 32'h1060; rng_mask[0] = 32'hF; rng_hi[0] = 3;
      cond_ctl[1] = 32'h07;
      trig_en = 2'b11; merge_and = 1'b1;
      rearm("R7"); cyc(1, 32'h03, 0, "R7 and", 0); cyc(1, 32'h83, 0, "R7 and", 1);
      rearm("R7"); cyc(1, 32'h00, 0, "R7 and", 0); cyc(1, 32'h80, 0, "R7 and", 0);
      merge_and = 1'b0;
      rearm("R7"); cyc(1, 32'h00, 0, "R7 or", 0); cyc(1, 32'h80, 0, "R7 or", 1);
      trig_en = 2'b01;
      rearm("R7"); cyc(1, 32'h00, 0, "R7 off", 0); cyc(1, 32'h80, 0, "R7 off", 0);

      // R8: once per arm, arm cycle ignores its sample
      base_cfg();
      cond_ctl[0] = 32'h1060;
      rearm("R8"); cyc(1, 5, 0, "R8", 1); cyc(1, 5, 0, "R8", 0); cyc(1, 5, 0, "R8", 0);
      cyc(1, 5, 1, "R8 arm+valid", 0); cyc(0, 5, 0, "R8 idle", 0); cyc(1, 5, 0, "R8", 1);

      // random windows against the model
      for (int b = 0; b < 120; b++) begin
         for (int k = 0; k < 2; k++) begin
            cond_ctl[k] = $urandom & 32'h0007_3F67;
            rng_mask[k] = $urandom & 32'hFF;
            pat_mask[k] = $urandom & 32'hFF;
            pat_data[k] = $urandom & 32'hFF;
            rng_lo[k]   = $urandom % 6;
            rng_hi[k]   = $urandom % 8;
            dur_lo[k]   = CW'($urandom % 4);
            dur_hi[k]   = CW'($urandom % 8);
         end
         trig_en = 2'($urandom); merge_and = 1'($urandom);
         rearm("R6 random");
         for (int i = 0; i < 30; i++)
            cyc(($urandom % 8) != 0, $urandom & 32'hFF, 0, "R5 random");
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule